// File: doc/BRIEF.md
# Switchable-Depth UART Receive Queue

This block is the receive-side character store of a UART. The deserialiser hands it one received character at a time, each with its framing-error and parity-error flags, and the line monitor can also hand it a break marker. Characters leave through a pop strobe that the data-register read path raises. The queue holds sixteen entries while the queue-mode input is high and a single entry while it is low. Every edge of that input empties the store.

The block keeps a read pointer and an occupancy count. It drives registered full and empty flags. It also drives a ready output that the deserialiser uses to decide whether the next character can be taken. A receive interrupt request bit goes high when a push brings the occupancy exactly onto a programmable trigger level. It goes low when a pop leaves the occupancy exactly one below that level, or when software clears it.

Top module: `uart_rx_fifo`

## Requirements
- R1: The effective depth is DEPTH (16) while `fifo_en_i` is high and 1 while it is low. `ready_o` is high exactly when `count_o` is below the effective depth.
- R2: An accepted push stores the entry at slot (read pointer + count) wrapped to the effective depth, increments `count_o`, clears `empty_o`, and sets `full_o` when the count reaches the effective depth. The entry layout is: bits 7:0 data, bit 8 framing error, bit 9 parity error, bit 10 break, bit 11 overrun.
- R3: A push that finds no free slot is dropped. The count and the stored characters stay unchanged, and bit 11 (overrun) of the most recently stored entry is set.
- R4: `pop_data_o` always shows the entry at the read pointer. A pop always clears `full_o`. It decrements the count and advances the read pointer only when the count is non-zero, and it sets `empty_o` when the resulting count is zero.
- R5: When a pop and a push arrive in the same cycle, the pop is applied first, so a push into a full queue accompanied by a pop is accepted.
- R6: In the cycle after `fifo_en_i` changes value, the count and read pointer are zero, `empty_o` is high and `full_o` is low. Pushes and pops in the cycle of the change are ignored, and `rx_irq_o` keeps its value.
- R7: `rx_irq_o` is set by an accepted push whose resulting count equals the trigger level.
- R8: `rx_irq_o` is cleared by a pop whose resulting count plus one equals the trigger level, including a pop of an empty queue when the level is 1. It is also cleared by `irq_clr_i`. A set from a push in the same cycle wins over either clear.
- R9: The trigger level is 1 after reset and after any `cfg_wr_i` pulse. `trig_wr_i` loads `trig_val_i`, with 0 taken as 1. `cfg_wr_i` wins when both are high.
- R10: `break_i` pushes an entry with data 0 and bit 10 set, unless `loopback_i` is high, in which case nothing is stored. A break takes precedence over `push_i` in the same cycle, and that character is dropped.
- R11: Reset gives count 0, `empty_o` high, `full_o` low, `rx_irq_o` low, trigger level 1 and single-entry mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en_i | input | 1 | Queue mode: 1 = DEPTH entries, 0 = one entry |
| loopback_i | input | 1 | Loopback active; suppresses break pushes |
| push_i | input | 1 | Push a received character |
| push_data_i | input | 8 | Received character |
| push_frm_i | input | 1 | Framing error of the character |
| push_par_i | input | 1 | Parity error of the character |
| break_i | input | 1 | Break event from the line |
| pop_i | input | 1 | Data-register read strobe |
| cfg_wr_i | input | 1 | Line-control or level write; resets trigger to 1 |
| trig_wr_i | input | 1 | Load the trigger level |
| trig_val_i | input | CNT_W | New trigger level |
| irq_clr_i | input | 1 | Clear the receive interrupt bit |
| pop_data_o | output | 12 | Entry at the read pointer |
| count_o | output | CNT_W | Occupancy |
| full_o | output | 1 | Queue full flag |
| empty_o | output | 1 | Queue empty flag |
| ready_o | output | 1 | A character can be accepted |
| rx_irq_o | output | 1 | Receive interrupt request bit |

## Verification
Count, full, empty, interrupt and trigger level are registers, so they change on the first rising edge after the strobe that causes them. The head entry and the ready output are decoded combinationally from that registered state, so they are also valid one edge later. The bench changes its inputs on a falling edge. It then waits exactly one falling edge, with one rising edge in between, before it reads any result. A flush caused by a mode change is checked on that same following falling edge.

// File: rtl/uart_rx_fifo_pkg.sv
package uart_rx_fifo_pkg;

  localparam int unsigned RXQ_DW      = 8;
  localparam int unsigned RXQ_ENTRY_W = RXQ_DW + 4;

  // MSB first: overrun, break, parity error, framing error, data
  typedef struct packed {
    logic              ovr;
    logic              brk;
    logic              par;
    logic              frm;
    logic [RXQ_DW-1:0] data;
  } rxq_entry_t;

endpackage

// File: rtl/uart_rx_fifo_store.sv
module uart_rx_fifo_store
  import uart_rx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en_i,
  input  logic [PTR_W-1:0] wr_slot_i,
  input  rxq_entry_t       wr_entry_i,
  input  logic             ovr_en_i,
  input  logic [PTR_W-1:0] ovr_slot_i,
  input  logic [PTR_W-1:0] rd_pos_i,
  output rxq_entry_t       rd_entry_o
);

  rxq_entry_t slots_q [DEPTH];

  // Storage carries no reset; occupancy is tracked by the controller.
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_en_i && (wr_slot_i == PTR_W'(i))) begin
        slots_q[i] <= wr_entry_i;
      end else if (ovr_en_i && (ovr_slot_i == PTR_W'(i))) begin
        slots_q[i].ovr <= 1'b1;
      end
    end
  end

  assign rd_entry_o = slots_q[rd_pos_i];

endmodule

// File: rtl/uart_rx_fifo_ctrl.sv
module uart_rx_fifo_ctrl #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned PTR_W = $clog2(DEPTH),
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fen_i,
  input  logic             push_i,
  input  logic             pop_i,
  output logic             mode_chg_o,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wr_slot_o,
  output logic             ovr_en_o,
  output logic [PTR_W-1:0] ovr_slot_o,
  output logic [PTR_W-1:0] rd_pos_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             ready_o,
  output logic             pop_fire_o,
  output logic [CNT_W-1:0] cnt_pop_o,
  output logic             push_ok_o,
  output logic [CNT_W-1:0] cnt_push_o
);

  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] MASK_C  = PTR_W'(DEPTH - 1);

  logic             fen_q;
  logic [CNT_W-1:0] cnt_q, cnt_n, cnt_p;
  logic [PTR_W-1:0] rd_q, rd_n, rd_p;
  logic             full_q, full_n, full_p;
  logic             empty_q, empty_n, empty_p;
  logic [CNT_W-1:0] depth_eff;
  logic [PTR_W-1:0] mask;
  logic             mode_chg, pop_fire, push_fire, push_ok;
  logic [CNT_W-1:0] cnt_push;

  assign depth_eff = fen_q ? DEPTH_C : CNT_W'(1);
  assign mask      = fen_q ? MASK_C  : '0;
  assign mode_chg  = fen_i ^ fen_q;
  assign pop_fire  = pop_i  & ~mode_chg;
  assign push_fire = push_i & ~mode_chg;

  // Pop stage: applied before the push of the same cycle
  always_comb begin
    cnt_p   = cnt_q;
    rd_p    = rd_q;
    full_p  = full_q;
    empty_p = empty_q;
    if (pop_fire) begin
      full_p = 1'b0;
      if (cnt_q != '0) begin
        cnt_p = cnt_q - CNT_W'(1);
        rd_p  = (rd_q + PTR_W'(1)) & mask;
      end
      if (cnt_p == '0) begin
        empty_p = 1'b1;
      end
    end
  end

  // Push stage
  assign push_ok   = push_fire && (cnt_p < depth_eff);
  assign cnt_push  = cnt_p + CNT_W'(1);
  assign wr_slot_o = (rd_p + PTR_W'(cnt_p)) & mask;
  assign ovr_slot_o = (rd_p + PTR_W'(cnt_p) - PTR_W'(1)) & mask;
  assign wr_en_o   = push_ok;
  assign ovr_en_o  = push_fire && !push_ok;

  // Next state
  always_comb begin
    if (mode_chg) begin
      cnt_n   = '0;
      rd_n    = '0;
      empty_n = 1'b1;
      full_n  = 1'b0;
    end else if (push_ok) begin
      cnt_n   = cnt_push;
      rd_n    = rd_p;
      empty_n = 1'b0;
      full_n  = (cnt_push == depth_eff);
    end else begin
      cnt_n   = cnt_p;
      rd_n    = rd_p;
      empty_n = empty_p;
      full_n  = full_p;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fen_q   <= 1'b0;
      cnt_q   <= '0;
      rd_q    <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      fen_q   <= fen_i;
      cnt_q   <= cnt_n;
      rd_q    <= rd_n;
      full_q  <= full_n;
      empty_q <= empty_n;
    end
  end

  assign mode_chg_o = mode_chg;
  assign rd_pos_o   = rd_q;
  assign count_o    = cnt_q;
  assign full_o     = full_q;
  assign empty_o    = empty_q;
  assign ready_o    = cnt_q < depth_eff;
  assign pop_fire_o = pop_fire;
  assign cnt_pop_o  = cnt_p;
  assign push_ok_o  = push_ok;
  assign cnt_push_o = cnt_push;

endmodule

// File: rtl/uart_rx_fifo_irq.sv
module uart_rx_fifo_irq #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_i,
  input  logic             trig_wr_i,
  input  logic [CNT_W-1:0] trig_val_i,
  input  logic             irq_clr_i,
  input  logic             pop_fire_i,
  input  logic [CNT_W-1:0] cnt_pop_i,
  input  logic             push_ok_i,
  input  logic [CNT_W-1:0] cnt_push_i,
  output logic [CNT_W-1:0] trig_o,
  output logic             irq_o
);

  logic [CNT_W-1:0] trig_q, trig_n;
  logic             irq_q, irq_n;
  logic             irq_set, irq_clr;

  assign irq_clr = irq_clr_i ||
                   (pop_fire_i && (({1'b0, cnt_pop_i} + (CNT_W+1)'(1)) == {1'b0, trig_q}));
  assign irq_set = push_ok_i && (cnt_push_i == trig_q);

  always_comb begin
    irq_n = irq_set | (irq_q & ~irq_clr);
    if (cfg_wr_i) begin
      trig_n = CNT_W'(1);
    end else if (trig_wr_i) begin
      trig_n = (trig_val_i == '0) ? CNT_W'(1) : trig_val_i;
    end else begin
      trig_n = trig_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= CNT_W'(1);
      irq_q  <= 1'b0;
    end else begin
      trig_q <= trig_n;
      irq_q  <= irq_n;
    end
  end

  assign trig_o = trig_q;
  assign irq_o  = irq_q;

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_fifo_pkg::*;
#(
  parameter  int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fifo_en_i,
  input  logic                   loopback_i,
  input  logic                   push_i,
  input  logic [RXQ_DW-1:0]      push_data_i,
  input  logic                   push_frm_i,
  input  logic                   push_par_i,
  input  logic                   break_i,
  input  logic                   pop_i,
  input  logic                   cfg_wr_i,
  input  logic                   trig_wr_i,
  input  logic [CNT_W-1:0]       trig_val_i,
  input  logic                   irq_clr_i,
  output logic [RXQ_ENTRY_W-1:0] pop_data_o,
  output logic [CNT_W-1:0]       count_o,
  output logic                   full_o,
  output logic                   empty_o,
  output logic                   ready_o,
  output logic                   rx_irq_o
);

  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic             brk_sel, push_any, mode_chg;
  rxq_entry_t       wr_entry, rd_entry;
  logic             wr_en, ovr_en, pop_fire, push_ok;
  logic [PTR_W-1:0] wr_slot, ovr_slot, rd_pos;
  logic [CNT_W-1:0] cnt_pop, cnt_push, trig;

  assign brk_sel  = break_i & ~loopback_i;
  assign push_any = brk_sel | push_i;

  always_comb begin
    wr_entry = '0;
    if (brk_sel) begin
      wr_entry.brk = 1'b1;
    end else begin
      wr_entry.data = push_data_i;
      wr_entry.frm  = push_frm_i;
      wr_entry.par  = push_par_i;
    end
  end

  uart_rx_fifo_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .fen_i     (fifo_en_i),
    .push_i    (push_any),
    .pop_i     (pop_i),
    .mode_chg_o(mode_chg),
    .wr_en_o   (wr_en),
    .wr_slot_o (wr_slot),
    .ovr_en_o  (ovr_en),
    .ovr_slot_o(ovr_slot),
    .rd_pos_o  (rd_pos),
    .count_o   (count_o),
    .full_o    (full_o),
    .empty_o   (empty_o),
    .ready_o   (ready_o),
    .pop_fire_o(pop_fire),
    .cnt_pop_o (cnt_pop),
    .push_ok_o (push_ok),
    .cnt_push_o(cnt_push)
  );

  uart_rx_fifo_store #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
    .clk       (clk),
    .wr_en_i   (wr_en),
    .wr_slot_i (wr_slot),
    .wr_entry_i(wr_entry),
    .ovr_en_i  (ovr_en),
    .ovr_slot_i(ovr_slot),
    .rd_pos_i  (rd_pos),
    .rd_entry_o(rd_entry)
  );

  uart_rx_fifo_irq #(.CNT_W(CNT_W)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr_i  (cfg_wr_i),
    .trig_wr_i (trig_wr_i),
    .trig_val_i(trig_val_i),
    .irq_clr_i (irq_clr_i),
    .pop_fire_i(pop_fire),
    .cnt_pop_i (cnt_pop),
    .push_ok_i (push_ok),
    .cnt_push_i(cnt_push),
    .trig_o    (trig),
    .irq_o     (rx_irq_o)
  );

  assign pop_data_o = rd_entry;

endmodule

// File: rtl/uart_rx_fifo_chk.sv
module uart_rx_fifo_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pop_i,
  input logic             push_i,
  input logic             push_any,
  input logic             break_i,
  input logic             loopback_i,
  input logic             irq_clr_i,
  input logic             mode_chg,
  input logic [CNT_W-1:0] trig,
  input logic [CNT_W-1:0] count_o,
  input logic             full_o,
  input logic             empty_o,
  input logic             ready_o,
  input logic             rx_irq_o
);

  assert_ready_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> !ready_o);

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CNT_W'(DEPTH));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && push_any && !pop_i && !mode_chg) |=> ($stable(count_o) && full_o));

  assert_empty_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    empty_o == (count_o == '0));

  assert_pop_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_any && !mode_chg && (count_o != '0)) |=>
      (count_o == $past(count_o) - CNT_W'(1)));

  assert_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> ((count_o == '0) && empty_o && !full_o));

  assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_irq_o) |-> (count_o == $past(trig)));

  assert_irq_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr_i && !push_any) |=> !rx_irq_o);

  assert_break_loop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (break_i && loopback_i && !push_i && !pop_i && !mode_chg) |=> $stable(count_o));

endmodule

bind uart_rx_fifo uart_rx_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pop_i     (pop_i),
  .push_i    (push_i),
  .push_any  (push_any),
  .break_i   (break_i),
  .loopback_i(loopback_i),
  .irq_clr_i (irq_clr_i),
  .mode_chg  (mode_chg),
  .trig      (trig),
  .count_o   (count_o),
  .full_o    (full_o),
  .empty_o   (empty_o),
  .ready_o   (ready_o),
  .rx_irq_o  (rx_irq_o)
);

// File: tb/uart_rx_fifo_tb_top.sv
`timescale 1ns/1ps
module uart_rx_fifo_tb_top;

  localparam int unsigned CNT_W = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic fifo_en_i, loopback_i, push_i, push_frm_i, push_par_i, break_i, pop_i;
  logic cfg_wr_i, trig_wr_i, irq_clr_i;
  logic [7:0] push_data_i;
  logic [CNT_W-1:0] trig_val_i;
  logic [11:0] pop_data_o;
  logic [CNT_W-1:0] count_o;
  logic full_o, empty_o, ready_o, rx_irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  uart_rx_fifo #(.DEPTH(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_en_i(fifo_en_i), .loopback_i(loopback_i),
    .push_i(push_i), .push_data_i(push_data_i), .push_frm_i(push_frm_i),
    .push_par_i(push_par_i), .break_i(break_i), .pop_i(pop_i), .cfg_wr_i(cfg_wr_i),
    .trig_wr_i(trig_wr_i), .trig_val_i(trig_val_i), .irq_clr_i(irq_clr_i),
    .pop_data_o(pop_data_o), .count_o(count_o), .full_o(full_o), .empty_o(empty_o),
    .ready_o(ready_o), .rx_irq_o(rx_irq_o)
  );

  // {fen, push, pop, data[7:0], exp_cnt[4:0], exp_empty, exp_full, exp_irq, exp_head[7:0]}
  localparam int NV = 16;
  localparam logic [26:0] VEC [NV] = '{
    {1'b1,1'b0,1'b0,8'h00, 5'd0,1'b1,1'b0,1'b0, 8'h00},
    {1'b1,1'b1,1'b0,8'hA1, 5'd1,1'b0,1'b0,1'b1, 8'hA1},
    {1'b1,1'b1,1'b0,8'hB2, 5'd2,1'b0,1'b0,1'b1, 8'hA1},
    {1'b1,1'b1,1'b0,8'hC3, 5'd3,1'b0,1'b0,1'b1, 8'hA1},
    {1'b1,1'b0,1'b1,8'h00, 5'd2,1'b0,1'b0,1'b1, 8'hB2},
    {1'b1,1'b1,1'b1,8'hD4, 5'd2,1'b0,1'b0,1'b1, 8'hC3},
    {1'b1,1'b0,1'b1,8'h00, 5'd1,1'b0,1'b0,1'b1, 8'hD4},
    {1'b1,1'b0,1'b1,8'h00, 5'd0,1'b1,1'b0,1'b0, 8'h00},
    {1'b1,1'b0,1'b1,8'h00, 5'd0,1'b1,1'b0,1'b0, 8'h00},
    {1'b1,1'b1,1'b0,8'h5E, 5'd1,1'b0,1'b0,1'b1, 8'h5E},
    {1'b0,1'b1,1'b0,8'h66, 5'd0,1'b1,1'b0,1'b1, 8'h00},
    {1'b0,1'b1,1'b0,8'h77, 5'd1,1'b0,1'b1,1'b1, 8'h77},
    {1'b0,1'b1,1'b0,8'h88, 5'd1,1'b0,1'b1,1'b1, 8'h77},
    {1'b0,1'b0,1'b1,8'h00, 5'd0,1'b1,1'b0,1'b0, 8'h00},
    {1'b0,1'b1,1'b0,8'h99, 5'd1,1'b0,1'b1,1'b1, 8'h99},
    {1'b0,1'b0,1'b1,8'h00, 5'd0,1'b1,1'b0,1'b0, 8'h00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic idle();
    push_i = 0; pop_i = 0; break_i = 0; cfg_wr_i = 0; trig_wr_i = 0; irq_clr_i = 0;
    push_frm_i = 0; push_par_i = 0; push_data_i = 8'h00;
  endtask

  task automatic push_c(input logic [7:0] d, input logic f, input logic p);
    push_i = 1; push_data_i = d; push_frm_i = f; push_par_i = p;
    cyc();
    idle();
  endtask

  task automatic pop_c();
    pop_i = 1;
    cyc();
    idle();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; fifo_en_i = 0; loopback_i = 0; trig_val_i = '0;
    idle();
    repeat (3) cyc();
    // R11 reset state
    chk("R11 count", count_o, 0);
    chk("R11 empty", empty_o, 1);
    chk("R11 full", full_o, 0);
    chk("R11 irq", rx_irq_o, 0);
    chk("R11 ready", ready_o, 1);
    rst_n = 1;
    cyc();

    // Vector table
    for (int i = 0; i < NV; i++) begin
      fifo_en_i   = VEC[i][26];
      push_i      = VEC[i][25];
      pop_i       = VEC[i][24];
      push_data_i = VEC[i][23:16];
      cyc();
      chk("R2/R4/R6 table count", count_o, VEC[i][15:11]);
      chk("R2/R4/R6 table empty", empty_o, VEC[i][10]);
      chk("R2/R4/R6 table full", full_o, VEC[i][9]);
      chk("R7/R8 table irq", rx_irq_o, VEC[i][8]);
      if (VEC[i][15:11] != 0) chk("R4 table head", pop_data_o[7:0], VEC[i][7:0]);
    end
    idle();

    // R1/R2/R3: fill sixteen entries, then overflow
    fifo_en_i = 1;
    cyc();
    for (int i = 0; i < 16; i++) begin
      push_c(8'h10 + 8'(i), 1'b0, 1'b0);
      if (i == 14) chk("R1 ready below depth", ready_o, 1);
    end
    chk("R2 full at depth", full_o, 1);
    chk("R1 ready at depth", ready_o, 0);
    chk("R2 count at depth", count_o, 16);
    push_c(8'hEE, 1'b0, 1'b0);
    chk("R3 count after drop", count_o, 16);
    chk("R3 full after drop", full_o, 1);
    for (int i = 0; i < 16; i++) begin
      chk("R3 order and overrun bit", pop_data_o, {(i == 15), 3'b000, 8'h10 + 8'(i)});
      pop_c();
      chk("R4 full clears on pop", full_o, 0);
    end
    chk("R4 empty after drain", empty_o, 1);

    // R7/R8/R9 trigger level
    trig_wr_i = 1; trig_val_i = 5'd4; cyc(); idle();
    push_c(8'h01, 0, 0); push_c(8'h02, 0, 0); push_c(8'h03, 0, 0);
    chk("R7 no irq below trigger", rx_irq_o, 0);
    push_c(8'h04, 0, 0);
    chk("R7 irq at trigger", rx_irq_o, 1);
    pop_c();
    chk("R8 pop leaves trigger-1", rx_irq_o, 0);
    cfg_wr_i = 1; cyc(); idle();
    pop_c(); pop_c(); pop_c();
    chk("R4 count after pops", count_o, 0);
    push_c(8'h05, 0, 0);
    chk("R9 trigger back to 1", rx_irq_o, 1);
    irq_clr_i = 1; cyc(); idle();
    chk("R8 software clear", rx_irq_o, 0);
    trig_wr_i = 1; trig_val_i = 5'd0; cyc(); idle();
    pop_c();
    push_c(8'h06, 0, 0);
    chk("R9 zero treated as 1", rx_irq_o, 1);
    pop_c();
    chk("R8 pop clears at level 1", rx_irq_o, 0);
    irq_clr_i = 1; push_i = 1; push_data_i = 8'h07; cyc(); idle();
    chk("R8 set wins over clear", rx_irq_o, 1);
    pop_c();

    // R10 break
    loopback_i = 1; break_i = 1; cyc(); idle();
    chk("R10 loopback suppresses break", count_o, 0);
    loopback_i = 0; break_i = 1; cyc(); idle();
    chk("R10 break count", count_o, 1);
    chk("R10 break entry", pop_data_o, 12'h400);
    break_i = 1; push_i = 1; push_data_i = 8'h55; cyc(); idle();
    chk("R10 break wins over char", count_o, 2);
    pop_c();
    chk("R10 second entry is break", pop_data_o, 12'h400);
    pop_c();

    // R2 error bits
    push_c(8'h3C, 1'b1, 1'b0);
    chk("R2 framing bit", pop_data_o, 12'h13C);
    pop_c();
    push_c(8'h3D, 1'b0, 1'b1);
    chk("R2 parity bit", pop_data_o, 12'h23D);
    pop_c();

    // R1/R5 single-entry mode, push with pop into a full slot
    fifo_en_i = 0; cyc();
    push_c(8'h11, 0, 0);
    chk("R1 single entry full", full_o, 1);
    chk("R1 single entry not ready", ready_o, 0);
    push_i = 1; push_data_i = 8'h22; pop_i = 1; cyc(); idle();
    chk("R5 count after pop+push", count_o, 1);
    chk("R5 head after pop+push", pop_data_o, 12'h022);
    chk("R5 full after pop+push", full_o, 1);

    // R11 reset mid-run
    trig_wr_i = 1; trig_val_i = 5'd3; cyc(); idle();
    rst_n = 0; cyc(); cyc();
    chk("R11 reset count", count_o, 0);
    chk("R11 reset empty", empty_o, 1);
    chk("R11 reset full", full_o, 0);
    chk("R11 reset irq", rx_irq_o, 0);
    rst_n = 1; cyc();
    push_c(8'h44, 0, 0);
    chk("R11 trigger 1 after reset", rx_irq_o, 1);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule